// File: doc/BRIEF.md
# Background Flash CRC Scanner

This block computes a CRC-32 over a byte range of flash memory while the processor keeps running. It reads one 32-byte flash word at a time through a read port that always gives way to system traffic. It waits a programmable number of wait states for each read, then pushes the wanted bytes of that word through a one-byte-per-clock CRC stage. The range may start at any byte address and may have any length. Bytes of the first word below the start offset are skipped, and the last word stops at the final byte of the message.

Between two word fetches the engine can pause for a programmable number of slow period-clock ticks. This limits how much flash bandwidth the scan takes. A one-cycle `start` pulse loads the configuration. At the end of each pass `done` pulses and the result is registered. In repeat mode the engine begins a fresh pass on its own each time one ends.

Top module: `flash_crc_scan`

## Requirements
- R1: After reset, `rd_req` and `done` are 0 and `crc_out` is 0.
- R2: `rd_req` is high only in a cycle where `sys_busy` is low. A pending fetch waits, through any number of busy cycles, until the first cycle in which `sys_busy` is low.
- R3: A fetch issued on clock edge E is captured from `rd_data` on edge E+FWS+1. The captured bytes then enter the CRC one per clock, and there is one `rd_req` cycle per fetch.
- R4: `rd_addr` is the word index, which is the byte address divided by 32. Byte k of a word is `rd_data[8k+7:8k]`, and the bytes of a word are used in increasing address order.
- R5: The CRC is CRC-32 with reflected polynomial 0xEDB88320, seed 0xFFFFFFFF, and the result inverted. The nine ASCII bytes "123456789" give 0xCBF43926.
- R6: A pass covers exactly `cfg_len` bytes, starting at byte address `cfg_addr`, whatever the alignment of the start address or the length.
- R7: After the last byte of a word is processed, the next fetch is requested only after `cfg_period` further `per_tick` pulses. With a period of 0, the fetch is requested in the very next cycle.
- R8: A start with `cfg_len` equal to 0 pulses `done` in the next cycle, and `crc_out` becomes 0x00000000.
- R9: With `cfg_repeat` set, a new pass begins after each pass ends. The new pass reloads the seed and the start address, and waits the period gap first. Every pass over unchanged memory reports the same result.
- R10: `done` is a one-cycle pulse in the cycle after the last byte is processed. `crc_out` changes only together with `done` and otherwise holds its value.
- R11: A `start` pulse during a pass abandons that pass and begins the newly configured one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that loads the configuration and begins a pass |
| cfg_addr | input | 20 | Start byte address |
| cfg_len | input | 20 | Message length in bytes |
| cfg_period | input | 12 | Gap between fetches, in period ticks |
| cfg_fws | input | 4 | Flash wait states |
| cfg_repeat | input | 1 | Restart automatically after each pass |
| per_tick | input | 1 | One-cycle enable from the slow period clock |
| sys_busy | input | 1 | System is using the flash port in this cycle |
| rd_req | output | 1 | Issue a flash word read in this cycle |
| rd_addr | output | 15 | Word index of the read |
| rd_data | input | 256 | Flash word; must be valid FWS+1 edges after the request |
| done | output | 1 | Pass complete pulse |
| crc_out | output | 32 | Result of the last completed pass |

## Verification
`rd_req` is combinational on `sys_busy`, so it is due in the same cycle as the idle slot. Read data is taken FWS+1 edges after the issue edge. `done` and `crc_out` appear one edge after the final byte, or one edge after a zero-length start. The bench drives inputs on the falling edge and steps a behavioural byte-level model on the rising edge. It compares every output a quarter period after the falling edge, so each result is checked in exactly the cycle it is due. Directed checks then confirm the known CRC value, the single-cycle `done`, the zero-length case and repeat stability.

// File: rtl/flash_crc_pkg.sv
package flash_crc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_CRC,
        ST_GAP
    } scan_st_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;
endpackage

// File: rtl/fcs_crc_step.sv
module fcs_crc_step
    import flash_crc_pkg::*;
(
    input  logic [31:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [31:0] crc_nx
);
    logic [31:0] acc;

    // Reflected byte update, one bit per loop pass, lsb first.
    always_comb begin
        acc = crc_in ^ {24'h0, data_in};
        for (int i = 0; i < 8; i++) begin
            acc = acc[0] ? ((acc >> 1) ^ CRC_POLY_REFL) : (acc >> 1);
        end
        crc_nx = acc;
    end
endmodule

// File: rtl/fcs_lane_pick.sv
module fcs_lane_pick #(
    parameter int WORD_BYTES = 32,
    localparam int OFF_W     = $clog2(WORD_BYTES),
    localparam int WORD_W    = WORD_BYTES * 8
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic [OFF_W-1:0]  sel,
    output logic [7:0]        byte_out
);
    logic [7:0] lanes [WORD_BYTES];

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign lanes[g] = word_in[g*8 +: 8];
    end

    assign byte_out = lanes[sel];
endmodule

// File: rtl/fcs_gap_timer.sv
module fcs_gap_timer #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PER_W-1:0] load_val,
    input  logic             tick,
    output logic             fin
);
    logic [PER_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (tick && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    // Finishes on the tick that consumes the last count.
    assign fin = tick && (cnt_q == PER_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/flash_crc_scan.sv
module flash_crc_scan
    import flash_crc_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int LEN_W      = 20,
    parameter int PER_W      = 12,
    parameter int FWS_W      = 4,
    parameter int WORD_BYTES = 32,
    localparam int OFF_W     = $clog2(WORD_BYTES),
    localparam int WORD_W    = WORD_BYTES * 8,
    localparam int WADDR_W   = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic [PER_W-1:0]   cfg_period,
    input  logic [FWS_W-1:0]   cfg_fws,
    input  logic               cfg_repeat,
    input  logic               per_tick,
    input  logic               sys_busy,
    output logic               rd_req,
    output logic [WADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0]  rd_data,
    output logic               done,
    output logic [31:0]        crc_out
);
    typedef struct packed {
        scan_st_e          st;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] ptr;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  left;
        logic [PER_W-1:0]  per;
        logic [FWS_W-1:0]  fws;
        logic [FWS_W-1:0]  wcnt;
        logic              rpt;
        logic [31:0]       crc;
        logic [31:0]       res;
        logic              done;
        logic [WORD_W-1:0] word;
    } regs_t;

    regs_t    r_d, r_q;
    logic     tmr_load, tmr_fin;
    logic [7:0]  cur_byte;
    logic [31:0] crc_nx;
    scan_st_e after_word;

    fcs_lane_pick #(.WORD_BYTES(WORD_BYTES)) u_lane (
        .word_in (r_q.word),
        .sel     (r_q.ptr[OFF_W-1:0]),
        .byte_out(cur_byte)
    );

    fcs_crc_step u_step (
        .crc_in (r_q.crc),
        .data_in(cur_byte),
        .crc_nx (crc_nx)
    );

    fcs_gap_timer #(.PER_W(PER_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(r_q.per),
        .tick    (per_tick),
        .fin     (tmr_fin)
    );

    assign after_word = (r_q.per == '0) ? ST_REQ : ST_GAP;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        rd_req   = 1'b0;
        tmr_load = 1'b0;
        unique case (r_q.st)
            ST_REQ: begin
                if (!sys_busy) begin
                    rd_req   = 1'b1;
                    r_d.wcnt = r_q.fws;
                    r_d.st   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (r_q.wcnt == '0) begin
                    r_d.word = rd_data;
                    r_d.st   = ST_CRC;
                end else begin
                    r_d.wcnt = r_q.wcnt - 1'b1;
                end
            end
            ST_CRC: begin
                r_d.crc  = crc_nx;
                r_d.ptr  = r_q.ptr + 1'b1;
                r_d.left = r_q.left - 1'b1;
                if (r_q.left == LEN_W'(1)) begin
                    r_d.done = 1'b1;
                    r_d.res  = ~crc_nx;
                    if (r_q.rpt) begin
                        r_d.crc  = CRC_SEED;
                        r_d.ptr  = r_q.base;
                        r_d.left = r_q.len;
                        r_d.st   = after_word;
                        tmr_load = (after_word == ST_GAP);
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end else if (&r_q.ptr[OFF_W-1:0]) begin
                    r_d.st   = after_word;
                    tmr_load = (after_word == ST_GAP);
                end
            end
            ST_GAP: begin
                if (tmr_fin) r_d.st = ST_REQ;
            end
            default: ;
        endcase

        if (start) begin
            r_d.base = cfg_addr;
            r_d.ptr  = cfg_addr;
            r_d.len  = cfg_len;
            r_d.left = cfg_len;
            r_d.per  = cfg_period;
            r_d.fws  = cfg_fws;
            r_d.rpt  = cfg_repeat;
            r_d.crc  = CRC_SEED;
            if (cfg_len == '0) begin
                r_d.done = 1'b1;
                r_d.res  = ~CRC_SEED;
                r_d.st   = ST_IDLE;
            end else begin
                r_d.st = ST_REQ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_addr = r_q.ptr[ADDR_W-1:OFF_W];
    assign done    = r_q.done;
    assign crc_out = r_q.res;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int LEN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] cfg_len,
    input logic             sys_busy,
    input logic             rd_req,
    input logic             done,
    input logic [31:0]      crc_out
);
    assert_yield_to_system_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !sys_busy);

    assert_one_issue_per_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !start) |=> !rd_req);

    assert_empty_message_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cfg_len == '0) |=> done);

    assert_result_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(crc_out));
endmodule

bind flash_crc_scan fcs_checker #(.LEN_W(LEN_W)) u_fcs_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cfg_len (cfg_len),
    .sys_busy(sys_busy),
    .rd_req  (rd_req),
    .done    (done),
    .crc_out (crc_out)
);

// File: tb/test_flash_crc_scan.sv
module test_flash_crc_scan;
    localparam int MEMSZ = 4096;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [19:0]  cfg_addr = '0;
    logic [19:0]  cfg_len = '0;
    logic [11:0]  cfg_period = '0;
    logic [3:0]   cfg_fws = '0;
    logic         cfg_repeat = 1'b0;
    logic         per_tick = 1'b0;
    logic         sys_busy = 1'b0;
    logic         rd_req;
    logic [14:0]  rd_addr;
    logic [255:0] rd_data;
    logic         done;
    logic [31:0]  crc_out;

    logic [7:0] mem [MEMSZ];
    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int busy_pct = 30;
    logic [31:0] lfsr = 32'h1234_5678;

    flash_crc_scan i_flash_crc_scan (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_addr(cfg_addr),
        .cfg_len(cfg_len), .cfg_period(cfg_period), .cfg_fws(cfg_fws),
        .cfg_repeat(cfg_repeat), .per_tick(per_tick), .sys_busy(sys_busy),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .crc_out(crc_out)
    );

    always #10 clk = ~clk;

    // Flash model: word at rd_addr, byte k in bits [8k+7:8k].
    always_comb begin
        for (int k = 0; k < 32; k++)
            rd_data[k*8 +: 8] = mem[(int'(rd_addr) * 32 + k) % MEMSZ];
    end

    // Background stimulus on the falling edge.
    always @(negedge clk) begin
        lfsr <= {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        sys_busy <= (int'(lfsr[9:0]) % 100) < busy_pct;
        per_tick <= (cyc % 6) == 0;
    end

    function automatic logic [31:0] crc_upd(logic [31:0] c, logic [7:0] b);
        for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = c[0] ^ b[k];
            c  = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c;
    endfunction

    // Behavioural reference: 0 idle, 1 want fetch, 2 waiting, 3 hashing, 4 gap.
    int m_st, m_ptr, m_left, m_wait, m_ticks;
    int m_base, m_len, m_per, m_fws;
    bit m_rpt, m_done;
    logic [31:0] m_crc, m_res;

    task automatic m_after_word();
        if (m_per == 0) m_st = 1;
        else begin m_st = 4; m_ticks = 0; end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_done = 0; m_res = 0; m_crc = 0; m_ptr = 0; m_left = 0;
            m_wait = 0; m_ticks = 0; m_base = 0; m_len = 0; m_per = 0; m_fws = 0; m_rpt = 0;
        end else begin
            m_done = 0;
            case (m_st)
                1: if (!sys_busy) begin m_st = 2; m_wait = 0; end
                2: if (m_wait == m_fws) m_st = 3; else m_wait++;
                3: begin
                    m_crc = crc_upd(m_crc, mem[m_ptr % MEMSZ]);
                    m_ptr++;
                    m_left--;
                    if (m_left == 0) begin
                        m_done = 1;
                        m_res  = ~m_crc;
                        if (m_rpt) begin
                            m_crc = 32'hFFFFFFFF; m_ptr = m_base; m_left = m_len;
                            m_after_word();
                        end else m_st = 0;
                    end else if (m_ptr % 32 == 0) m_after_word();
                end
                4: if (per_tick) begin
                    m_ticks++;
                    if (m_ticks == m_per) m_st = 1;
                end
                default: ;
            endcase
            if (start) begin
                m_base = int'(cfg_addr); m_ptr = m_base; m_len = int'(cfg_len);
                m_left = m_len; m_per = int'(cfg_period); m_fws = int'(cfg_fws);
                m_rpt = cfg_repeat; m_crc = 32'hFFFFFFFF;
                if (m_len == 0) begin m_done = 1; m_res = 32'h0; m_st = 0; end
                else m_st = 1;
            end
        end
    end

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison, a quarter period after the falling edge.
    always @(negedge clk) begin
        #5;
        if (rst_n) begin
            check32("R2/R3/R7 rd_req", 32'(rd_req), 32'(m_st == 1 && !sys_busy));
            if (m_st == 1 && !sys_busy)
                check32("R4 rd_addr", 32'(rd_addr), 32'(15'(m_ptr / 32)));
            check32("R6/R10 done", 32'(done), 32'(m_done));
            check32("R5/R9 crc_out", crc_out, m_res);
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog R6: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic kick(int a, int l, int p, int f, bit r);
        @(negedge clk);
        cfg_addr = 20'(a); cfg_len = 20'(l); cfg_period = 12'(p);
        cfg_fws = 4'(f); cfg_repeat = r; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        forever begin
            @(negedge clk); #6;
            if (done) break;
        end
    endtask

    string digits = "123456789";
    logic [31:0] first_res;

    initial begin
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'((i * 37 + (i >> 4) * 11) ^ 8'h5A);
        for (int i = 0; i < 9; i++) mem[12'h21C + i] = digits[i];

        repeat (3) @(negedge clk);
        #6;
        // R1: reset state
        check32("R1 rd_req at reset", 32'(rd_req), 32'h0);
        check32("R1 done at reset", 32'(done), 32'h0);
        check32("R1 crc_out at reset", crc_out, 32'h0);
        rst_n = 1'b1;

        // R5: known vector crossing a word boundary, R10 pulse width
        kick(12'h21C, 9, 3, 2, 1'b0);
        wait_done();
        check32("R5 check value", crc_out, 32'hCBF43926);
        @(negedge clk); #6;
        check32("R10 done single cycle", 32'(done), 32'h0);
        check32("R10 crc_out held", crc_out, 32'hCBF43926);

        // R8: empty message
        kick(12'h100, 0, 0, 0, 1'b0);
        #6;
        check32("R8 done after empty start", 32'(done), 32'h1);
        check32("R8 empty result", crc_out, 32'h0);

        // R2 R6 R7: unaligned, no gap, heavy system traffic
        busy_pct = 70;
        kick(12'h013, 150, 0, 0, 1'b0);
        wait_done();
        busy_pct = 20;

        // R3 R4: aligned, long wait states, gap
        kick(12'h040, 64, 5, 7, 1'b0);
        wait_done();

        // R9: repeat passes give identical results
        kick(12'h005, 40, 2, 1, 1'b1);
        wait_done();
        first_res = crc_out;
        wait_done();
        check32("R9 second pass", crc_out, first_res);
        wait_done();
        check32("R9 third pass", crc_out, first_res);

        // R11: restart in the middle of a pass
        kick(12'h200, 200, 1, 3, 1'b0);
        repeat (30) @(negedge clk);
        kick(12'h21C, 9, 0, 0, 1'b0);
        wait_done();
        check32("R11 restarted result", crc_out, 32'hCBF43926);

        repeat (20) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule